// File: doc/BRIEF.md
# Cascadable 16-bit Magnitude Comparator with Signed Mode

This block compares two 16-bit operands in a single combinational pass and reports exactly one of three relations: A below B, A equal to B, or A above B. It is built from identical 4-bit compare slices. Each slice decides the relation locally when its two nibbles differ. When the nibbles match, it hands on whatever relation arrives from the slice below it. Four slices are chained so that the most significant differing nibble settles the answer.

A mode input selects how the operands are read: plain unsigned binary, or two's complement. In signed mode the sign bit of each operand is flipped before the unsigned chain sees it, so a negative operand always ranks below a non-negative one. A maximum output returns the larger operand under the selected reading, picked by a multiplexer driven by the compare result. When the operands are equal, it returns operand A.

Top module: `cascade_cmp`

## Requirements
- R1: With `signed_mode_i` = 0, `lt_o`, `eq_o` and `gt_o` report the unsigned relation of `a_i` to `b_i`.
- R2: With `signed_mode_i` = 1, the three flags report the two's-complement relation of `a_i` to `b_i`.
- R3: For every input, exactly one of `lt_o`, `eq_o` and `gt_o` is 1.
- R4: `max_o` equals the larger operand under the selected mode. When the operands are equal, `max_o` equals `a_i`.
- R5: The relation is set by the most significant 4-bit nibble (bits 15:12 first, then 11:8, 7:4, 3:0) in which the operands differ. The bits below that nibble have no effect on the result.
- R6: Identical operands give `eq_o` = 1 in both modes, including all-zero and all-one patterns.
- R7: In signed mode, when the sign bits (bit 15) differ, the operand whose sign bit is 1 is reported as the smaller. This holds even where its unsigned value is larger, for example 0x8000 against 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| signed_mode_i | input | 1 | 1 = two's-complement compare, 0 = unsigned compare |
| lt_o | output | 1 | A is smaller than B |
| eq_o | output | 1 | A equals B |
| gt_o | output | 1 | A is larger than B |
| max_o | output | 16 | Larger operand; A when the operands are equal |

## Verification
Whenever the inputs change, the embedded assertions check four things. The three flags are one-hot. `max_o` is always one of the two operands. `eq_o` tracks bitwise identity. The flags agree with the relation of the mode in force. Inside each slice, an assertion checks that equal nibbles hand on the cascade inputs unchanged.

Some behaviours can only be shown by the bench's directed scenarios. One is that lower nibbles are ignored once a higher nibble differs, which needs operand pairs built with deliberately conflicting low bits. Another is the signed boundary ordering around 0x7FFF and 0x8000. The last is that `max_o` picks A on a tie.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    localparam int unsigned NIB_W = 4;

    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
    } cmp_res_t;

    localparam cmp_res_t RES_LT = '{lt: 1'b1, eq: 1'b0, gt: 1'b0};
    localparam cmp_res_t RES_EQ = '{lt: 1'b0, eq: 1'b1, gt: 1'b0};
    localparam cmp_res_t RES_GT = '{lt: 1'b0, eq: 1'b0, gt: 1'b1};

    function automatic logic res_valid(input cmp_res_t r);
        return (r.lt + r.eq + r.gt) == 2'd1;
    endfunction

endpackage

// File: rtl/cmp_slice.sv
module cmp_slice
    import cmp_pkg::*;
#(
    parameter int unsigned W = NIB_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  cmp_res_t     casc_i,
    output cmp_res_t     res_o
);

    logic [W-1:0] bit_same;
    logic         nib_same;
    logic         above;
    logic         below;
    logic         upper_same;

    // Per-bit equality via XNOR; the whole nibble matches when all bits do.
    assign bit_same = ~(a_i ^ b_i);
    assign nib_same = &bit_same;

    // Scan from the top bit down; a bit pair only decides while all bits above it match.
    always_comb begin
        above      = 1'b0;
        below      = 1'b0;
        upper_same = 1'b1;
        for (int i = W - 1; i >= 0; i--) begin
            above      = above | (upper_same & a_i[i] & ~b_i[i]);
            below      = below | (upper_same & ~a_i[i] & b_i[i]);
            upper_same = upper_same & bit_same[i];
        end
    end

    always_comb begin
        if (above)      res_o = RES_GT;
        else if (below) res_o = RES_LT;
        else            res_o = casc_i;
    end

    // R5: a matching nibble forwards the lower decision untouched.
    always_comb begin
        if (nib_same) begin
            a_r5_slice_passthrough: assert (res_o == casc_i);
        end else begin
            a_r5_slice_decides: assert (res_o.eq == 1'b0 && res_valid(res_o));
        end
    end

endmodule

// File: rtl/cmp_chain.sv
module cmp_chain
    import cmp_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned SLICE_W = NIB_W
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output cmp_res_t          res_o
);

    localparam int unsigned N_SLICES = DATA_W / SLICE_W;

    // casc[k] feeds slice k from below; casc[N_SLICES] is the chain result.
    cmp_res_t casc [N_SLICES+1];

    assign casc[0] = RES_EQ;

    for (genvar g = 0; g < N_SLICES; g++) begin : g_slice
        cmp_slice #(.W(SLICE_W)) u_slice (
            .a_i    (a_i[g*SLICE_W +: SLICE_W]),
            .b_i    (b_i[g*SLICE_W +: SLICE_W]),
            .casc_i (casc[g]),
            .res_o  (casc[g+1])
        );
    end

    assign res_o = casc[N_SLICES];

endmodule

// File: rtl/cmp_sign_fix.sv
module cmp_sign_fix #(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              signed_mode_i,
    output logic [DATA_W-1:0] a_o,
    output logic [DATA_W-1:0] b_o
);

    localparam int unsigned MSB = DATA_W - 1;

    // Flipping the sign bit maps two's-complement order onto unsigned order.
    assign a_o = {a_i[MSB] ^ signed_mode_i, a_i[MSB-1:0]};
    assign b_o = {b_i[MSB] ^ signed_mode_i, b_i[MSB-1:0]};

endmodule

// File: rtl/max_sel.sv
module max_sel
    import cmp_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  cmp_res_t          res_i,
    output logic [DATA_W-1:0] max_o
);

    // B is chosen only when A is strictly smaller; ties return A.
    assign max_o = res_i.lt ? b_i : a_i;

endmodule

// File: rtl/cascade_cmp.sv
module cascade_cmp
    import cmp_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned SLICE_W = NIB_W
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              signed_mode_i,
    output logic              lt_o,
    output logic              eq_o,
    output logic              gt_o,
    output logic [DATA_W-1:0] max_o
);

    logic [DATA_W-1:0] a_adj;
    logic [DATA_W-1:0] b_adj;
    cmp_res_t          res;

    cmp_sign_fix #(.DATA_W(DATA_W)) u_sign_fix (
        .a_i           (a_i),
        .b_i           (b_i),
        .signed_mode_i (signed_mode_i),
        .a_o           (a_adj),
        .b_o           (b_adj)
    );

    cmp_chain #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_chain (
        .a_i   (a_adj),
        .b_i   (b_adj),
        .res_o (res)
    );

    max_sel #(.DATA_W(DATA_W)) u_max (
        .a_i   (a_i),
        .b_i   (b_i),
        .res_i (res),
        .max_o (max_o)
    );

    assign lt_o = res.lt;
    assign eq_o = res.eq;
    assign gt_o = res.gt;

    always_comb begin
        a_r3_one_hot: assert ($onehot({lt_o, eq_o, gt_o}));
        a_r4_max_is_operand: assert (max_o == a_i || max_o == b_i);
        a_r6_eq_tracks_identity: assert (eq_o == (a_i == b_i));
        if (signed_mode_i) begin
            a_r2_signed_order: assert (gt_o == ($signed(a_i) > $signed(b_i))
                                       && lt_o == ($signed(a_i) < $signed(b_i)));
        end else begin
            a_r1_unsigned_order: assert (gt_o == (a_i > b_i) && lt_o == (a_i < b_i));
        end
    end

endmodule

// File: tb/cascade_cmp_tb.sv
module cascade_cmp_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic [W-1:0] a, b;
    logic         smode;
    logic         lt, eq, gt;
    logic [W-1:0] mx;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cascade_cmp u_dut (
        .a_i (a), .b_i (b), .signed_mode_i (smode),
        .lt_o (lt), .eq_o (eq), .gt_o (gt), .max_o (mx)
    );

    // Applies one input pair, waits away from any edge and compares to a model of the requirements.
    task automatic check(input logic [W-1:0] va, input logic [W-1:0] vb,
                         input logic m, input string tag);
        logic e_lt, e_eq, e_gt;
        logic [W-1:0] e_mx;
        a = va; b = vb; smode = m;
        @(negedge clk);
        if (m) begin
            e_lt = $signed(va) < $signed(vb);
            e_gt = $signed(va) > $signed(vb);
        end else begin
            e_lt = va < vb;
            e_gt = va > vb;
        end
        e_eq = (va == vb);
        e_mx = e_lt ? vb : va;
        checks++;
        if ({lt, eq, gt} != {e_lt, e_eq, e_gt} || mx !== e_mx) begin
            errors++;
            $display("FAIL %s: a=%h b=%h mode=%0d got lt/eq/gt=%b%b%b max=%h expected %b%b%b max=%h",
                     tag, va, vb, m, lt, eq, gt, mx, e_lt, e_eq, e_gt, e_mx);
        end
    endtask

    task automatic t_idle_zero();
        check(16'h0000, 16'h0000, 1'b0, "R6 zero operands");
    endtask

    task automatic t_unsigned();
        check(16'h1234, 16'h1235, 1'b0, "R1 lt by one");
        check(16'hFFFF, 16'h0000, 1'b0, "R1 full scale gt");
        check(16'h8000, 16'h7FFF, 1'b0, "R1 top bit unsigned gt");
        check(16'h00F0, 16'h0F00, 1'b0, "R1 R4 max picks b");
    endtask

    task automatic t_signed();
        check(16'hFFFF, 16'h0001, 1'b1, "R2 minus one below one");
        check(16'hFFFE, 16'hFFFF, 1'b1, "R2 both negative");
        check(16'h0100, 16'h00FF, 1'b1, "R2 both positive");
        check(16'hFF00, 16'h0001, 1'b1, "R2 R4 max picks b in signed");
    endtask

    task automatic t_sign_edge();
        check(16'h8000, 16'h7FFF, 1'b1, "R7 most negative below most positive");
        check(16'h7FFF, 16'h8000, 1'b1, "R7 reversed");
        check(16'h8000, 16'h0000, 1'b1, "R7 negative below zero");
    endtask

    task automatic t_priority();
        check(16'h2000, 16'h1FFF, 1'b0, "R5 top nibble overrides lower");
        check(16'h5A00, 16'h5BFF, 1'b0, "R5 second nibble decides");
        check(16'h55F0, 16'h550F, 1'b0, "R5 third nibble decides");
        check(16'h5554, 16'h5555, 1'b0, "R5 bottom nibble decides");
    endtask

    task automatic t_equal();
        check(16'hFFFF, 16'hFFFF, 1'b0, "R6 all ones unsigned");
        check(16'hFFFF, 16'hFFFF, 1'b1, "R6 all ones signed");
        check(16'hA5C3, 16'hA5C3, 1'b1, "R6 R4 tie returns a");
    endtask

    task automatic t_sweep();
        logic [W-1:0] s = 16'hACE1;
        for (int i = 0; i < 200; i++) begin
            logic [W-1:0] va;
            s  = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
            va = s;
            s  = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
            check(va, (i % 7 == 0) ? va : s, i[0], "R3 sweep one-hot and order");
        end
    endtask

    initial begin
        a = '0; b = '0; smode = 1'b0;
        repeat (2) @(posedge clk);
        t_idle_zero();
        t_unsigned();
        t_signed();
        t_sign_edge();
        t_priority();
        t_equal();
        t_sweep();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule